// File: doc/BRIEF.md
# Glitch-Free Two-Clock Switch

This block chooses one of two input clocks and drives the chosen one onto a single clock output. The two clocks may be unrelated in frequency and phase. When the select input changes, the block hands the output over from one clock to the other without producing a glitch. Every high and low phase on the output is at least as long as the shortest phase of either input.

Each input clock has its own enable. That enable is synchronized on the clock's own falling edge, so it only moves while that clock is low. A clock may take the output only after the other side's synchronizer has fully emptied. The two gated clocks are ORed together, so the output stays low during the handover.

The same switch also serves as a gated clock buffer. If `clk_b` is held low, setting `sel` high parks the output low after the last full high phase of `clk_a`. Setting `sel` low again resumes `clk_a`.

Top module: `clk_switch`

## Requirements
- R1: While `rst_n` is low, `clk_a` is the driving clock. After reset with `sel` low, `clk_out` follows `clk_a`, with the same period and high time.
- R2: With `sel` low and settled, `clk_out` follows `clk_a`.
- R3: With `sel` high and settled, `clk_out` follows `clk_b`.
- R4: Across any sequence of `sel` changes, no high or low phase of `clk_out` is shorter than the shortest half-period of the two input clocks.
- R5: At no time are both clocks enabled onto the output. The outgoing enable is cleared before the incoming one is set.
- R6: Each clock's enable changes only while that clock is low, so a high phase on the output is never cut short or started mid-phase.
- R7: With `clk_b` held low, setting `sel` high parks `clk_out` low with no further edges. Setting `sel` low again restores `clk_a` on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock driven when `sel` is low |
| clk_b | input | 1 | Clock driven when `sel` is high; tie low for gated-buffer use |
| sel | input | 1 | Clock choice: 0 selects `clk_a`, 1 selects `clk_b` |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_out | output | 1 | Switched clock output |

## Verification
The assertions assume that `sel` never changes within a setup window before the edge at which the active synchronizer samples it. Inside that window, real silicon can produce a runt pulse, and that case is undefined rather than a pass or fail. In simulation there is no metastability, so the stimulus can sweep select pulses of every spacing from 1 ns to 60 ns. The two clock periods are chosen so that their falling edges never coincide, which keeps the two synchronizers from sampling each other's state in the same time step. The gated-buffer case stops `clk_b` only after `sel` has been low long enough for the `clk_b` side to have fully released.

// File: rtl/clk_switch.sv
module clk_switch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic sel,
  input  logic rst_n,
  output logic clk_out
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] chain_a, chain_b;
  logic en_a, en_b, busy_a, busy_b;

  assign en_a   = chain_a[TOP];
  assign en_b   = chain_b[TOP];
  assign busy_a = |chain_a;
  assign busy_b = |chain_b;

  always_ff @(negedge clk_a or negedge rst_n)
    if (!rst_n) chain_a <= '1;
    else        chain_a <= {chain_a[TOP-1:0], ~sel & ~busy_b};

  always_ff @(negedge clk_b or negedge rst_n)
    if (!rst_n) chain_b <= '0;
    else        chain_b <= {chain_b[TOP-1:0], sel & ~busy_a};

  assign clk_out = (clk_a & en_a) | (clk_b & en_b);

  always_comb
    if (rst_n) AST_ONE_OWNER: assert (!(en_a && en_b)); // R5

  always @(en_a)
    if (rst_n) AST_A_GATE_LOW: assert (!clk_a); // R6

  always @(en_b)
    if (rst_n) AST_B_GATE_LOW: assert (!clk_b); // R6

  always @(posedge clk_out)
    if (rst_n) AST_EDGE_HAS_OWNER: assert (en_a || en_b); // R4

endmodule

// File: tb/tb_clk_switch.sv
`timescale 1ns/1ps
module tb_clk_switch;
  localparam real HA = 7.0;
  localparam real HB = 11.0;
  localparam real MINH = 7.0;

  logic clk = 0, clk_a = 0, clk_b_raw = 0, b_run = 1, sel = 0, rst_n = 0;
  logic clk_b;
  logic clk_out;
  int checks = 0, errors = 0;
  bit mon_on = 0;
  real last_t = 0.0;
  bit have_last = 0;
  int edges = 0;

  assign clk_b = clk_b_raw & b_run;

  clk_switch dut (.clk_a(clk_a), .clk_b(clk_b), .sel(sel), .rst_n(rst_n), .clk_out(clk_out));

  always #10 clk = ~clk;
  always #(HA) clk_a = ~clk_a;
  initial begin
    #3;
    forever #(HB) clk_b_raw = ~clk_b_raw;
  end

  task automatic check(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
    end
  endtask

  always @(clk_out) begin
    edges++;
    if (mon_on) begin
      if (have_last)
        check(($realtime - last_t) >= MINH - 0.001, "R4/R6 phase width", $realtime - last_t, MINH);
      last_t = $realtime;
      have_last = 1;
    end
  end

  task automatic follow(input string req, input real half);
    real t1, t2, t3;
    @(posedge clk_out); t1 = $realtime;
    @(negedge clk_out); t2 = $realtime;
    @(posedge clk_out); t3 = $realtime;
    check((t3 - t1) > 2.0*half - 0.001 && (t3 - t1) < 2.0*half + 0.001, {req, " period"}, t3 - t1, 2.0*half);
    check((t2 - t1) > half - 0.001 && (t2 - t1) < half + 0.001, {req, " high time"}, t2 - t1, half);
  endtask

  initial begin
    #1;
    #5; check(clk_out === clk_a, "R1 reset drives clk_a", clk_out, clk_a);
    #50 rst_n = 1;
    follow("R1", HA);
    mon_on = 1;
    sel = 1; #300; follow("R3", HB);
    sel = 0; #300; follow("R2", HA);
    for (int d = 1; d <= 60; d++) begin
      sel = ~sel; #(d);
      sel = ~sel; #(d + 3);
    end
    for (int i = 0; i < 200; i++) begin
      sel = $urandom_range(0, 1); #($urandom_range(1, 80));
    end
    sel = 1; #300; follow("R3 after sweep", HB);
    sel = 0; #300; follow("R2 after sweep", HA);
    b_run = 0;
    sel = 1; #300;
    edges = 0; #500;
    check(edges == 0, "R7 parked edges", edges, 0);
    check(clk_out === 1'b0, "R7 parked level", clk_out, 0);
    sel = 0; #300; follow("R7 resume", HA);
    for (int d = 1; d <= 40; d++) begin
      sel = ~sel; #(2*d);
    end
    sel = 0; #300; follow("R7 after gating sweep", HA);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule